// File: doc/BRIEF.md
# Transmit Request Scheduler for Eight Message Buffers

This block keeps the per-buffer control and status bits for eight message buffers of a CAN-style controller and decides which pending transmit buffer is handed next to a protocol engine. Software configures the buffers through four 16-bit control words. Each word covers a pair of buffers: the low byte covers the even-numbered buffer and the high byte covers the odd-numbered one. Software can set a buffer to transmit or receive, give it a priority, request a send, withdraw a request, and allow remote frames to raise a request automatically.

The engine side works with one buffer at a time. When no buffer is outstanding and at least one transmit buffer is pending, the block raises a one-cycle start strobe together with the chosen buffer index. The engine then answers with exactly one result: sent, lost arbitration, bus error or abort acknowledged. A buffer that loses arbitration or sees a bus error keeps its request and competes again in the next cycle. A request that software withdraws before the buffer is started is aborted at once. A request withdrawn while the buffer is in flight raises an abort request to the engine, and the abort completes when the engine acknowledges it.

Top module: `msgbuf_sched`

## Requirements
- R1: After reset every control word reads 0x0000, and neither the start strobe nor the engine abort request is asserted.
- R2: A buffer whose direction bit (byte bit 7) is 0 is never started, whatever its request and priority bits hold.
- R3: Among pending transmit buffers the start picks the one with the largest 2-bit priority (3 beats 2 beats 1 beats 0). On equal priority the larger buffer index wins.
- R4: A sent result clears the request bit (byte bit 3) of the in-flight buffer, leaves its status bits unchanged, and frees the engine.
- R5: Writing 0 to a request bit that is 1 on a buffer that has not been started clears the request and sets the aborted bit (byte bit 6) at the same clock edge. No engine abort request is raised.
- R6: Writing 0 to the request bit of the in-flight buffer clears the request and holds the engine abort request high. The aborted bit is set, and the abort request drops, at the edge on which the engine acknowledges the abort.
- R7: Software writes to the aborted, lost-arbitration and error bits (byte bits 6, 5, 4) have no effect on them.
- R8: When a request bit goes from 0 to 1, the aborted, lost-arbitration and error bits of that buffer clear at the same edge.
- R9: A lost-arbitration result sets the lost-arbitration bit (byte bit 5), and a bus-error result sets the error bit (byte bit 4). In both cases the request stays set and the buffer can be started again in the next cycle.
- R10: A remote-frame event for a buffer whose auto-remote enable (byte bit 2) is 1 sets that buffer's request. When the enable is 0, the event leaves the control word unchanged.
- R11: Word n holds buffer 2n in bits 7:0 and buffer 2n+1 in bits 15:8. Each byte holds, from bit 7 down to bit 0: direction, aborted, lost-arbitration, error, request, auto-remote enable, priority[1:0].
- R12: A start is only issued when no buffer is outstanding with the engine. A buffer counts as outstanding from its start until the engine returns a result for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write strobe for the addressed control word |
| cfgAddr | input | 2 | Control word select for both read and write |
| cfgWrData | input | 16 | Control word write value |
| cfgRdData | output | 16 | Control word read value for cfgAddr |
| rtrValid | input | 1 | Remote frame received |
| rtrIdx | input | 3 | Buffer the remote frame is addressed to |
| engStart | output | 1 | One-cycle start of the buffer on engIndex |
| engIndex | output | 3 | Buffer selected for, or held by, the engine |
| engDone | input | 1 | In-flight buffer was sent |
| engLostArb | input | 1 | In-flight buffer lost arbitration |
| engBusErr | input | 1 | In-flight buffer hit a bus error |
| engAbortAck | input | 1 | Engine has aborted the in-flight buffer |
| engAbortReq | output | 1 | Abort requested for the in-flight buffer |

## Verification
Every write, remote-frame event and engine result acts on the next rising edge. Its effect on cfgRdData is therefore visible in the cycle that follows that edge. The start strobe and the engine abort request are decoded directly from the stored state, so a start caused by a write or a retry shows up in that same following cycle. The outstanding marker is set one edge later. The bench drives every input on a falling edge, holds it through one rising edge, and samples the outputs at the next falling edge, which is exactly the cycle in which each result is due.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;
  localparam int IDX_W_MAX = 8;
  localparam int PRIO_W    = 2;

  // per-buffer byte layout; the read side and software both depend on it
  localparam int F_DIR  = 7;
  localparam int F_ABT  = 6;
  localparam int F_LOST = 5;
  localparam int F_ERR  = 4;
  localparam int F_REQ  = 3;
  localparam int F_RTR  = 2;

  typedef struct packed {
    logic                 busy;
    logic [IDX_W_MAX-1:0] curIdx;
    logic                 done;
    logic                 lostArb;
    logic                 busErr;
    logic                 abortDone;
  } engStb_t;
endpackage

// File: rtl/msgbuf_pick.sv
module msgbuf_pick #(
  parameter int NUM_BUF = 8,
  parameter int PRIO_W  = 2,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_BUF-1:0]        candVec,
  input  logic [NUM_BUF*PRIO_W-1:0] prioFlat,
  output logic                      anyCand,
  output logic [IDX_W-1:0]          winIdx
);
  logic [PRIO_W-1:0] bestPrio;

  // ascending scan with >= lets the higher index win a tie
  always_comb begin
    anyCand  = 1'b0;
    winIdx   = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (candVec[i] && (!anyCand || prioFlat[i*PRIO_W +: PRIO_W] >= bestPrio)) begin
        anyCand  = 1'b1;
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
        winIdx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/msgbuf_ctrl.sv
module msgbuf_ctrl
  import msgbuf_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_BUF-1:0]        candVec,
  input  logic [NUM_BUF*PRIO_W-1:0] prioFlat,
  input  logic [NUM_BUF-1:0]        abortPendVec,
  input  logic                      engDone,
  input  logic                      engLostArb,
  input  logic                      engBusErr,
  input  logic                      engAbortAck,
  output logic                      engStart,
  output logic [IDX_W-1:0]          engIndex,
  output logic                      engAbortReq,
  output engStb_t                   stb
);
  logic             busy;
  logic [IDX_W-1:0] curIdx;
  logic             anyCand;
  logic [IDX_W-1:0] winIdx;
  logic             anyResult;

  msgbuf_pick #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) uPick (
    .candVec (candVec),
    .prioFlat(prioFlat),
    .anyCand (anyCand),
    .winIdx  (winIdx)
  );

  assign anyResult   = engDone | engLostArb | engBusErr | engAbortAck;
  assign engStart    = !busy && anyCand;
  assign engIndex    = busy ? curIdx : winIdx;
  assign engAbortReq = busy && abortPendVec[curIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      curIdx <= '0;
    end else if (engStart) begin
      busy   <= 1'b1;
      curIdx <= winIdx;
    end else if (busy && anyResult) begin
      busy   <= 1'b0;
    end
  end

  // one result per handoff; sent outranks abort outranks the retry causes
  always_comb begin
    stb.busy      = busy;
    stb.curIdx    = IDX_W_MAX'(curIdx);
    stb.done      = busy && engDone;
    stb.abortDone = busy && engAbortAck && !engDone;
    stb.lostArb   = busy && engLostArb && !engDone && !engAbortAck;
    stb.busErr    = busy && engBusErr && !engDone && !engAbortAck && !engLostArb;
  end
endmodule

// File: rtl/msgbuf_regs.sv
module msgbuf_regs
  import msgbuf_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int IDX_W   = 3,
  parameter int ADDR_W  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [15:0]               cfgWrData,
  output logic [15:0]               cfgRdData,
  input  logic                      rtrValid,
  input  logic [IDX_W-1:0]          rtrIdx,
  input  engStb_t                   stb,
  output logic [NUM_BUF-1:0]        candVec,
  output logic [NUM_BUF*PRIO_W-1:0] prioFlat,
  output logic [NUM_BUF-1:0]        abortPendVec,
  output logic [NUM_BUF-1:0]        dirVec,
  output logic [NUM_BUF-1:0]        reqVec
);
  localparam int WORDS = NUM_BUF / 2;

  logic [7:0] ctlArr [NUM_BUF];

  for (genvar b = 0; b < NUM_BUF; b++) begin : gBuf
    logic              dir, abt, lost, err, req, rtrEn, abortPend;
    logic [PRIO_W-1:0] prio;
    logic [7:0]        wrByte;
    logic              wrHit, rtrHit, mine, inFlight;

    assign wrByte   = cfgWrData[(b % 2)*8 +: 8];
    assign wrHit    = cfgWrEn && (cfgAddr == ADDR_W'(b / 2));
    assign rtrHit   = rtrValid && (rtrIdx == IDX_W'(b)) && rtrEn;
    assign mine     = stb.curIdx == IDX_W_MAX'(b);
    assign inFlight = stb.busy && mine;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        {dir, abt, lost, err, req, rtrEn, abortPend} <= '0;
        prio <= '0;
      end else begin
        if (wrHit) begin
          dir   <= wrByte[F_DIR];
          rtrEn <= wrByte[F_RTR];
          prio  <= wrByte[PRIO_W-1:0];
          if (wrByte[F_REQ] && !req) begin
            req <= 1'b1;
            {abt, lost, err} <= '0;
          end else if (!wrByte[F_REQ] && req) begin
            req <= 1'b0;
            if (inFlight) abortPend <= 1'b1;
            else          abt       <= 1'b1;
          end
        end else if (rtrHit && !req) begin
          req <= 1'b1;
          {abt, lost, err} <= '0;
        end
        if (mine && stb.done) begin
          req       <= 1'b0;
          abortPend <= 1'b0;
        end
        if (mine && (stb.lostArb || stb.busErr)) begin
          if (stb.lostArb) lost <= 1'b1;
          if (stb.busErr)  err  <= 1'b1;
          if (abortPend) begin
            abt       <= 1'b1;
            abortPend <= 1'b0;
          end
        end
        if (mine && stb.abortDone) begin
          abt       <= 1'b1;
          abortPend <= 1'b0;
        end
      end
    end

    assign ctlArr[b]                     = {dir, abt, lost, err, req, rtrEn, prio};
    assign candVec[b]                    = dir && req && !abortPend;
    assign prioFlat[b*PRIO_W +: PRIO_W]  = prio;
    assign abortPendVec[b]               = abortPend;
    assign dirVec[b]                     = dir;
    assign reqVec[b]                     = req;
  end

  always_comb begin
    cfgRdData = '0;
    for (int a = 0; a < WORDS; a++)
      if (cfgAddr == ADDR_W'(a)) cfgRdData = {ctlArr[2*a+1], ctlArr[2*a]};
  end
endmodule

// File: rtl/msgbuf_sched.sv
module msgbuf_sched
  import msgbuf_pkg::*;
#(
  parameter int NUM_BUF = 8,
  localparam int IDX_W  = $clog2(NUM_BUF),
  localparam int ADDR_W = (NUM_BUF > 2) ? $clog2(NUM_BUF / 2) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [15:0]       cfgWrData,
  output logic [15:0]       cfgRdData,
  input  logic              rtrValid,
  input  logic [IDX_W-1:0]  rtrIdx,
  output logic              engStart,
  output logic [IDX_W-1:0]  engIndex,
  input  logic              engDone,
  input  logic              engLostArb,
  input  logic              engBusErr,
  input  logic              engAbortAck,
  output logic              engAbortReq
);
  engStb_t                   stb;
  logic [NUM_BUF-1:0]        candVec;
  logic [NUM_BUF*PRIO_W-1:0] prioFlat;
  logic [NUM_BUF-1:0]        abortPendVec;
  logic [NUM_BUF-1:0]        dirVec;
  logic [NUM_BUF-1:0]        reqVec;

  msgbuf_regs #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) uRegs (
    .clk, .rstN, .cfgWrEn, .cfgAddr, .cfgWrData, .cfgRdData,
    .rtrValid, .rtrIdx, .stb,
    .candVec, .prioFlat, .abortPendVec, .dirVec, .reqVec
  );

  msgbuf_ctrl #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) uCtrl (
    .clk, .rstN, .candVec, .prioFlat, .abortPendVec,
    .engDone, .engLostArb, .engBusErr, .engAbortAck,
    .engStart, .engIndex, .engAbortReq, .stb
  );
endmodule

// File: rtl/msgbuf_sched_chk.sv
module msgbuf_sched_chk #(
  parameter int NUM_BUF = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               engStart,
  input logic [IDX_W-1:0]   engIndex,
  input logic               engDone,
  input logic               engLostArb,
  input logic               engBusErr,
  input logic               engAbortAck,
  input logic               engAbortReq,
  input logic               cfgWrEn,
  input logic [NUM_BUF-1:0] dirVec,
  input logic [NUM_BUF-1:0] reqVec
);
  logic             outst;
  logic [IDX_W-1:0] trk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outst <= 1'b0;
      trk   <= '0;
    end else if (engStart) begin
      outst <= 1'b1;
      trk   <= engIndex;
    end else if (engDone || engLostArb || engBusErr || engAbortAck) begin
      outst <= 1'b0;
    end
  end

  assert_single_outstanding_R12: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> !outst);

  assert_start_is_transmit_R2: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> dirVec[engIndex]);

  assert_sent_clears_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outst && engDone) |=> !reqVec[trk]);

  assert_retry_keeps_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outst && (engLostArb || engBusErr) && !engDone && !engAbortAck && reqVec[trk] && !cfgWrEn)
      |=> reqVec[trk]);

  assert_abort_only_inflight_R6: assert property (@(posedge clk) disable iff (!rstN)
    engAbortReq |-> outst);
endmodule

bind msgbuf_sched msgbuf_sched_chk #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) uChk (.*);

// File: tb/sim_msgbuf_sched.sv
module sim_msgbuf_sched;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData;
  logic        rtrValid = 1'b0;
  logic [2:0]  rtrIdx = '0;
  logic        engStart;
  logic [2:0]  engIndex;
  logic        engDone = 1'b0, engLostArb = 1'b0, engBusErr = 1'b0, engAbortAck = 1'b0;
  logic        engAbortReq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  msgbuf_sched u0 (.*);

  // per-buffer nibble {dir, req, prio[1:0]}, buffer i in bits 4i+3:4i
  localparam int NV = 7;
  localparam logic [31:0] VEC_CFG [NV] = '{
    32'h0000_0D00, 32'h0E00_00F0, 32'h00E0_E00E, 32'h700C_0000,
    32'hCCCC_CCCC, 32'h0000_B00D, 32'h0070_0000 };
  // {startExpected, index}
  localparam logic [3:0] VEC_EXP [NV] = '{
    4'hA, 4'h9, 4'hD, 4'hC, 4'hF, 4'h8, 4'h0 };

  function automatic logic [15:0] mkWord(logic [31:0] cfg, int w);
    logic [3:0] lo, hi;
    lo = cfg[(2*w)*4 +: 4];
    hi = cfg[(2*w+1)*4 +: 4];
    return {hi[3], 3'b000, hi[2], 1'b0, hi[1:0], lo[3], 3'b000, lo[2], 1'b0, lo[1:0]};
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdData;
  endtask

  // 0 done, 1 lost arbitration, 2 bus error, 3 abort ack
  task automatic pulse(input int kind);
    @(negedge clk);
    engDone = (kind == 0); engLostArb = (kind == 1);
    engBusErr = (kind == 2); engAbortAck = (kind == 3);
    @(negedge clk);
    {engDone, engLostArb, engBusErr, engAbortAck} = '0;
  endtask

  task automatic rtr(input logic [2:0] idx);
    @(negedge clk);
    rtrValid = 1'b1; rtrIdx = idx;
    @(negedge clk);
    rtrValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d, 16'h0000, "R1 word after reset");
    end
    chk({15'd0, engStart}, 16'd0, "R1 no start after reset");
    chk({15'd0, engAbortReq}, 16'd0, "R1 no abort request after reset");

    // R11 layout, R7 status bits read-only
    wr(2'd2, 16'h0681);
    rd(2'd2, d); chk(d, 16'h0681, "R11 word2 field layout");
    rd(2'd1, d); chk(d, 16'h0000, "R11 neighbour word untouched");
    wr(2'd2, 16'h76F1);
    rd(2'd2, d); chk(d, 16'h0681, "R7 status bits ignore writes");

    // R10 remote frame
    rtr(3'd4);
    rd(2'd2, d); chk(d, 16'h0681, "R10 disabled buffer unchanged");
    rtr(3'd5);
    rd(2'd2, d); chk(d, 16'h0E81, "R10 enabled buffer request set");
    chk({15'd0, engStart}, 16'd0, "R2 receive buffer not started");
    wr(2'd2, 16'h0000);

    // in-flight handling on buffer 0
    wr(2'd0, 16'h0088);
    chk({12'd0, engStart, engIndex}, 16'h0008, "R12 start buffer 0");
    wr(2'd3, 16'h8B00);
    chk({15'd0, engStart}, 16'd0, "R12 no start while outstanding");
    wr(2'd3, 16'h0000);
    rd(2'd3, d); chk(d, 16'h4000, "R5 immediate abort of idle buffer");
    chk({15'd0, engAbortReq}, 16'd0, "R5 no engine abort handshake");
    pulse(1);
    rd(2'd0, d); chk(d, 16'h00A8, "R9 lost arbitration bit, request kept");
    chk({12'd0, engStart, engIndex}, 16'h0008, "R9 restart after lost arbitration");
    pulse(2);
    rd(2'd0, d); chk(d, 16'h00B8, "R9 error bit, request kept");
    chk({12'd0, engStart, engIndex}, 16'h0008, "R9 restart after bus error");
    wr(2'd0, 16'h0080);
    chk({15'd0, engAbortReq}, 16'd1, "R6 abort request while in flight");
    rd(2'd0, d); chk(d, 16'h00B0, "R6 aborted bit waits for ack");
    chk({15'd0, engStart}, 16'd0, "R6 no start while abort pending");
    pulse(3);
    rd(2'd0, d); chk(d, 16'h00F0, "R6 aborted bit after ack");
    chk({15'd0, engAbortReq}, 16'd0, "R6 abort request dropped");
    wr(2'd0, 16'h008B);
    rd(2'd0, d); chk(d, 16'h008B, "R8 setting request clears status");
    chk({12'd0, engStart, engIndex}, 16'h0008, "R8 start after new request");
    pulse(0);
    rd(2'd0, d); chk(d, 16'h0083, "R4 sent clears request");
    chk({15'd0, engStart}, 16'd0, "R4 engine idle after sent");

    // R3 / R2 selection table
    for (int v = 0; v < NV; v++) begin
      for (int w = 0; w < 4; w++) wr(2'(w), mkWord(VEC_CFG[v], w));
      if (VEC_EXP[v][3]) begin
        pulse(1);
        chk({12'd0, engStart, engIndex}, {12'd0, VEC_EXP[v]}, $sformatf("R3 R2 selection vector %0d", v));
      end else begin
        @(negedge clk);
        chk({15'd0, engStart}, 16'd0, $sformatf("R2 no transmit pending vector %0d", v));
      end
      for (int w = 0; w < 4; w++) wr(2'(w), 16'h0000);
      @(negedge clk);
      if (engAbortReq) pulse(3);
      @(negedge clk);
      chk({15'd0, engStart}, 16'd0, $sformatf("R12 idle after cleanup vector %0d", v));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule